// File: doc/BRIEF.md
# Burst SRAM access controller

This block is the clocked front end of a single-port pipelined burst SRAM with one shared data bus. It holds a small memory array in which each byte can be written on its own. At every rising clock edge it samples three chip enables, two address strobes, the write controls, the address bus and a burst-order select. A strobe loads the address into an address register and a 2-bit burst counter. An active-low advance input then steps the counter through a four-beat wrapping sequence. The sequence is either linear or interleaved.

The two strobes are a processor-side strobe and a controller-side strobe. The processor strobe has priority. A cycle it opens is always a read, and the controller strobe is ignored in that cycle. Only the controller strobe can open a write. Once a burst is open, cycles with no strobe continue it: they read, or they write when the write inputs are asserted. Read data is registered. It reaches the bus one clock after the address is taken, and only while the output enable is active and no write is being signalled. The bus drivers are released at once whenever the write inputs signal a write, whatever the output enable says.

Top module: `bsram_ctrl`

## Requirements
- R1: After a synchronous reset no read is pending and the design does not drive `dq`, even with `oe_n` low.
- R2: A write opened by a strobe happens only in these conditions: the chip is selected (`en_a_n` low, `en_b` high and `en_c_n` low), `ctrl_stb_n` is low, `proc_stb_n` is high, and a write is signalled. A strobe seen while the chip is not selected writes nothing and closes the burst.
- R3: When `proc_stb_n` is low on a selected cycle, `ctrl_stb_n` and the write inputs are ignored. The cycle reads the presented address and leaves memory unchanged.
- R4: On an accepted strobe the presented address is loaded. Its upper bits go to the address register and its two low bits seed the burst counter, and beat 0 accesses exactly that address.
- R5: A write is signalled when `gw_n` is low or when `bwe_n` is low with at least one `bw_n` bit low. `gw_n` low writes all bytes. Otherwise byte i, which is `dq[8i+7:8i]`, is written only when `bwe_n` and `bw_n[i]` are both low. Strobes on `bw_n` while `bwe_n` is high do nothing.
- R6: While a write is signalled, the design does not drive `dq`, regardless of `oe_n`.
- R7: With `mode` low, beat k accesses low bits (start + k) mod 4. The sequence wraps after four beats.
- R8: With `mode` at any value other than a known low, beat k accesses low bits start XOR k.
- R9: On a cycle with no strobe inside an open burst, `adv_n` low steps to the next beat. `adv_n` high holds the current beat. The upper address bits never change during a burst.
- R10: Read data appears on `dq` one clock after the edge that performed the read. It is driven only while `oe_n` is low and no write is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| proc_stb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | DW/8 | Per-byte write strobes, active low |
| addr | input | AW | Word address |
| mode | input | 1 | Burst order: low selects linear, otherwise interleaved |
| oe_n | input | 1 | Output enable, active low |
| dq | inout | DW | Shared data bus |

## Verification
Writes land in the array at the rising edge that samples them. Read data is due in the cycle after its read edge. The scoreboard pops each expected word at the falling edge after that read edge, and the bench changes the inputs only 1 ns after that falling edge, so each comparison sees the inputs of the read cycle. Bus release is combinational from the write inputs. It is therefore checked 1 ns after the write inputs are applied and before the next edge. For that check the bench drives a value that would be corrupted if the design also drove the bus.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  // Low address bits for a given beat: linear adds the beat index, interleaved XORs it.
  function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                         input logic [1:0] idx,
                                         input logic       lin);
    return lin ? 2'(base + idx) : (base ^ idx);
  endfunction

endpackage

// File: rtl/bsram_burst_addr.sv
module bsram_burst_addr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          clear,
  input  logic          step,
  input  logic          lin,
  input  logic [AW-1:0] ld_addr,
  output logic [AW-1:0] cur_addr,
  output logic          active
);
  import bsram_pkg::*;

  localparam int HW = AW - 2;

  logic [HW-1:0] hi_q;
  logic [1:0]    base_q;
  logic [1:0]    beat_q;
  logic [1:0]    beat_nx;

  assign beat_nx  = step ? 2'(beat_q + 2'd1) : beat_q;
  assign cur_addr = load ? ld_addr : {hi_q, beat_lo(base_q, beat_nx, lin)};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      base_q <= '0;
      beat_q <= '0;
      active <= 1'b0;
    end else if (load) begin
      hi_q   <= ld_addr[AW-1:2];
      base_q <= ld_addr[1:0];
      beat_q <= '0;
      active <= 1'b1;
    end else begin
      beat_q <= beat_nx;
      if (clear) active <= 1'b0;
    end
  end

  // R4: a load seeds the register and counter from the presented address
  a_r4_load_seed: assert property (@(posedge clk) disable iff (rst)
    load |=> (hi_q == $past(ld_addr[AW-1:2]) && base_q == $past(ld_addr[1:0]) && beat_q == 2'd0));

  // R9 / R7: an advance steps the beat by one, wrapping modulo 4
  a_r9_step_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> beat_q == 2'($past(beat_q) + 2'd1));

  // R9: without advance or load the beat and upper bits stay put
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(beat_q) && $stable(hi_q)));

endmodule

// File: rtl/bsram_byte_ram.sv
module bsram_byte_ram #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic [DW/8-1:0]   we,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam int NB    = DW / 8;
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (we[b])  mem[addr] <= wdata[b*8 +: 8];
      if (rd_en)  q         <= mem[addr];
    end

    assign rdata[b*8 +: 8] = q;
  end

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              en_c_n,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [DW/8-1:0]   bw_n,
  input  logic [AW-1:0]     addr,
  input  logic              mode,
  input  logic              oe_n,
  inout  wire  [DW-1:0]     dq
);
  localparam int NB = DW / 8;

  logic          sel, stb_any, start, start_proc, deselect, cont;
  logic          wr_det, wr_go, rd_go, step, lin, active;
  logic [NB-1:0] byte_we;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] rd_q;
  logic          rd_valid;
  logic          dq_oe;

  assign sel        = !en_a_n && en_b && !en_c_n;
  assign stb_any    = !proc_stb_n || !ctrl_stb_n;
  assign start      = sel && stb_any;
  assign start_proc = start && !proc_stb_n;
  assign deselect   = stb_any && !sel;
  assign cont       = active && !stb_any;
  assign step       = cont && !adv_n;
  assign lin        = (mode === 1'b0);

  assign wr_det = !gw_n || (!bwe_n && !(&bw_n));
  assign wr_go  = (start && proc_stb_n && wr_det) || (cont && wr_det);
  assign rd_go  = start_proc || (start && !wr_det) || (cont && !wr_det);

  for (genvar b = 0; b < NB; b++) begin : g_we
    assign byte_we[b] = wr_go && (!gw_n || (!bwe_n && !bw_n[b]));
  end

  bsram_burst_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .clear    (deselect),
    .step     (step),
    .lin      (lin),
    .ld_addr  (addr),
    .cur_addr (cur_addr),
    .active   (active)
  );

  bsram_byte_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (byte_we),
    .rd_en (rd_go),
    .addr  (cur_addr),
    .wdata (dq),
    .rdata (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_go;
  end

  assign dq_oe = rd_valid && !oe_n && !wr_det;
  assign dq    = dq_oe ? rd_q : 'z;

  // R3: the processor strobe never lets a byte be written in its cycle
  a_r3_proc_no_write: assert property (@(posedge clk) disable iff (rst)
    (!proc_stb_n && sel) |-> (byte_we == '0));

  // R2: a byte write needs an accepted controller start or an open burst without strobes
  a_r2_write_source: assert property (@(posedge clk) disable iff (rst)
    (|byte_we) |-> ((sel && !ctrl_stb_n && proc_stb_n) || (active && proc_stb_n && ctrl_stb_n)));

  // R10: the bus is driven only in the cycle after a read edge
  a_r10_read_latency: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(rd_go));

  // R5: a global write enables every byte lane
  a_r5_global_all: assert property (@(posedge clk) disable iff (rst)
    (wr_go && !gw_n) |-> (&byte_we));

endmodule

// File: tb/test_bsram_ctrl.sv
module test_bsram_ctrl;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int NB = DW / 8;

  typedef struct {
    logic [DW-1:0] v;
    string         r;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst;
  logic          en_a_n, en_b, en_c_n, proc_stb_n, ctrl_stb_n, adv_n;
  logic          gw_n, bwe_n, mode, oe_n;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic          drv;
  logic [DW-1:0] dat;
  wire  [DW-1:0] dq;

  logic [DW-1:0] mdl [1<<AW];
  exp_t          q[$];
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  localparam logic [DW-1:0] REL = '1;

  always #5 clk = ~clk;

  assign dq = drv ? dat : 'z;
  for (genvar g = 0; g < DW; g++) begin : g_pu
    pullup (dq[g]);
  end

  bsram_ctrl #(.DW(DW), .AW(AW)) i_bsram_ctrl (
    .clk(clk), .rst(rst), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr), .mode(mode),
    .oe_n(oe_n), .dq(dq)
  );

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string r);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic set_idle();
    en_a_n = 1; en_b = 0; en_c_n = 1;
    proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = '1; addr = '0;
    oe_n = 0; drv = 0; dat = '0;
  endtask

  task automatic sel_on();
    en_a_n = 0; en_b = 1; en_c_n = 0;
  endtask

  // One clock: inputs already applied; optionally queue the read result due next.
  task automatic go(input bit push = 0, input logic [DW-1:0] e = '0, input string r = "");
    exp_t it;
    @(posedge clk);
    if (push) begin
      it.v = e; it.r = r;
      q.push_back(it);
    end
    @(negedge clk);
    #1;
    set_idle();
  endtask

  function automatic logic [1:0] lin_lo(input logic [1:0] s, input logic [1:0] i);
    return 2'(s + i);
  endfunction

  // Monitor: compare at the falling edge following each read edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk(dq, it.v, it.r);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_idle();
    mode = 0;
    rst  = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;

    // R1: bus released after reset
    go(1, REL, "R1");

    // R2/R5/R9: controller-strobe burst write at 0x08, linear
    mode = 0;
    sel_on(); ctrl_stb_n = 0; addr = 6'h08; gw_n = 0; drv = 1; dat = 32'h1111_0000;
    mdl[8] = dat;
    go();
    for (int i = 1; i < 4; i++) begin
      adv_n = 0; gw_n = 0; drv = 1; dat = 32'h1111_0000 + i;
      mdl[{4'h2, lin_lo(2'd0, 2'(i))}] = dat;
      go();
    end

    // R4/R7/R9: processor-strobe read burst from 0x09, linear wrap 9,10,11,8
    sel_on(); proc_stb_n = 0; addr = 6'h09;
    go(1, mdl[9], "R4");
    for (int i = 1; i < 4; i++) begin
      adv_n = 0;
      go(1, mdl[{4'h2, lin_lo(2'd1, 2'(i))}], "R7");
    end
    go(1, mdl[8], "R9 hold");

    // R6: write signalled with oe_n low releases the bus immediately
    gw_n = 0; drv = 1; dat = 32'h2222_0005;
    #1;
    chk(dq, dat, "R6");
    mdl[8] = dat;
    go();
    go(1, mdl[8], "R6 readback");

    // R10: oe_n high hides the data, then it returns
    oe_n = 1;
    go(1, REL, "R10 oe high");
    go(1, mdl[8], "R10 oe low");

    // R8: interleaved from 0x09: 9,8,11,10
    mode = 1;
    sel_on(); proc_stb_n = 0; addr = 6'h09;
    go(1, mdl[9], "R8");
    for (int i = 1; i < 4; i++) begin
      adv_n = 0;
      go(1, mdl[{4'h2, 2'd1 ^ 2'(i)}], "R8");
    end
    mode = 0;

    // R5: partial byte write (lanes 0 and 2) at 0x0A
    sel_on(); ctrl_stb_n = 0; addr = 6'h0A; bwe_n = 0; bw_n = 4'b1010;
    drv = 1; dat = 32'hAABB_CCDD;
    mdl[10][7:0]   = 8'hDD;
    mdl[10][23:16] = 8'hBB;
    go();
    go(1, mdl[10], "R5 partial");

    // R5: bw_n low while bwe_n high is not a write; this is a read
    sel_on(); ctrl_stb_n = 0; addr = 6'h0A; bw_n = '0;
    go(1, mdl[10], "R5 no bwe");

    // R5: global write overrides bwe_n high
    sel_on(); ctrl_stb_n = 0; addr = 6'h0B; gw_n = 0; drv = 1; dat = 32'h5A5A_0F0F;
    mdl[11] = dat;
    go();
    go(1, mdl[11], "R5 global");

    // R2: write strobe with en_b low is dropped and closes the burst
    sel_on(); en_b = 0; ctrl_stb_n = 0; addr = 6'h09; gw_n = 0; drv = 1; dat = 32'h3333_3333;
    go();
    go(1, REL, "R2 closed");
    sel_on(); en_c_n = 1; ctrl_stb_n = 0; addr = 6'h09; gw_n = 0; drv = 1; dat = 32'h3333_3333;
    go();
    sel_on(); proc_stb_n = 0; addr = 6'h09;
    go(1, mdl[9], "R2 unchanged");

    // R3: both strobes low with a write signalled: read only
    sel_on(); proc_stb_n = 0; ctrl_stb_n = 0; addr = 6'h0A; gw_n = 0; drv = 1; dat = 32'h4444_4444;
    go();
    go(1, mdl[10], "R3");

    go();
    go();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule